// File: doc/BRIEF.md
# Event Timer Register Bank

This block is the shared control core of a three-channel event timer. It holds the 64-bit main counter, a read-only capability word, the global configuration (run and legacy routing) and, for each channel, a configuration register and a 64-bit comparator. The comparators themselves live in separate channel blocks. Those blocks watch the exported counter and report a match on `chan_fire`. This bank then turns each match into a single-cycle pulse on one of 32 interrupt lines.

Software reaches the registers over a plain 32-bit bus with a 10-bit byte address. The window layout is as follows:
- Global registers sit below 0x100.
- Channel n occupies 32 bytes starting at 0x100 + 0x20·n.
- Inside a channel window, configuration is at +0x00/+0x04 and the comparator at +0x08/+0x0C.
- Global offsets: capability 0x000/0x004, global configuration 0x010 (0x014 reads zero), status 0x020, counter 0x0F0 (low) and 0x0F4 (high).

Read data is registered and appears in the cycle after `bus_rd`. Writes take effect at the clock edge where `bus_wr` is high.

Clearing the run bit freezes the counter. Setting it again resumes counting from the frozen value. It also sends a one-cycle re-arm strobe to every channel whose comparator is not all ones. Writing a comparator while running also strobes that channel.

Top module: `evt_timer_regs`

## Requirements
- R1: After reset the counter is 0 and the capability low word reads 0x8086A201. The capability high word reads the tick period in femtoseconds. Each channel configuration reads 0x00000030 (low) and 0x00000C20 (high), each comparator reads all ones, and `irq_o` and `arm_o` are 0.
- R2: In the global configuration word only bit 0 (run) and bit 1 (legacy routing) can be written. Every other bit reads 0.
- R3: A channel configuration write changes only the bits in mask 0x3E4E; the rest keep their value. The high configuration word is read-only. Bit 2 is the channel interrupt enable and bits 13:9 are the route line.
- R4: Writes to the capability words and to the status word change nothing; status reads 0.
- R5: While running, the counter advances by exactly one on each cycle with `tick_en` high. While halted it holds its value.
- R6: A write to the counter's low or high word replaces only that 32-bit half. Such a write takes priority over a tick in the same cycle.
- R7: A write that sets run from 0 pulses `arm_o[n]` in the next cycle for every channel n whose comparator is not all ones. A comparator write while running pulses `arm_o` for that channel.
- R8: A `chan_fire[n]` pulse with the channel enable bit and run both set raises `irq_o[route]` for exactly one cycle, one cycle later. Without either enable, no line is raised.
- R9: In legacy mode channel 0 drives line 0 and channel 1 drives line 8, whatever their route field. Channel 2 keeps using its route field.
- R10: Reads of a channel index of 3 or more, and reads of undefined offsets, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance strobe |
| bus_addr | input | 10 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| chan_fire | input | 3 | Comparator match pulses from the channel blocks |
| cnt_o | output | 64 | Main counter value |
| run_o | output | 1 | Global run bit |
| chan_cfg_o | output | 96 | Low configuration word of each channel, channel 0 in the lowest bits |
| chan_cmp_o | output | 192 | Comparator of each channel, channel 0 in the lowest bits |
| arm_o | output | 3 | One-cycle re-arm strobes to the channel blocks |
| irq_o | output | 32 | One-cycle interrupt pulses, one bit per line |

## Verification
Embedded properties cover several behaviours on every cycle:
- the counter stepping by one per tick, holding while halted, and taking written halves;
- comparator words staying put unless written, and configuration writes landing under the mask;
- interrupt pulses never appearing while halted, and the legacy lines 0 and 8 firing when required;
- re-arm strobes occurring only while running.

Several things rest on the bench scenarios and their per-cycle reference model: the exact reset values, the readback of masked and read-only fields, that the capability and status words ignore writes, the choice of which channels re-arm, and zero returns from unmapped addresses.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 32;
  localparam int CNT_W    = 64;
  localparam int ROUTE_W  = 5;
  localparam int NLINES   = 1 << ROUTE_W;
  localparam int ROUTE_LO = 9;

  // global word addresses (byte address >> 2)
  localparam logic [7:0] WA_CAP_LO  = 8'h00;
  localparam logic [7:0] WA_CAP_HI  = 8'h01;
  localparam logic [7:0] WA_GCFG    = 8'h04;
  localparam logic [7:0] WA_STAT    = 8'h08;
  localparam logic [7:0] WA_CNT_LO  = 8'h3C;
  localparam logic [7:0] WA_CNT_HI  = 8'h3D;

  localparam logic [9:0] CH_BASE    = 10'h100;

  // word offsets inside a channel window
  localparam logic [2:0] CW_CFG_LO  = 3'd0;
  localparam logic [2:0] CW_CFG_HI  = 3'd1;
  localparam logic [2:0] CW_CMP_LO  = 3'd2;
  localparam logic [2:0] CW_CMP_HI  = 3'd3;

  localparam logic [31:0] CH_WMASK   = 32'h0000_3E4E;
  localparam logic [31:0] CH_CFG_RST = 32'h0000_0030;
  localparam int          CH_EN_BIT  = 2;
endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int CNT_W  = 64,
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick_en,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_lo) begin
      cnt_q[HALF_W-1:0] <= wdata;
    end else if (wr_hi) begin
      cnt_q[CNT_W-1:HALF_W] <= wdata[CNT_W-HALF_W-1:0];
    end else if (run && tick_en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    (run && tick_en && !wr_lo && !wr_hi) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_lo && !wr_hi) |=> $stable(cnt_q));
  a_r6_low_half: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> (cnt_q[HALF_W-1:0] == $past(wdata)) &&
              (cnt_q[CNT_W-1:HALF_W] == $past(cnt_q[CNT_W-1:HALF_W])));
  a_r6_high_half: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && !wr_lo) |=> cnt_q[HALF_W-1:0] == $past(cnt_q[HALF_W-1:0]));
endmodule

// File: rtl/evt_chan_regs.sv
module evt_chan_regs
  import evt_timer_pkg::*;
#(
  parameter logic [31:0] LINE_CAP = 32'h0000_0C20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cfg,
  input  logic              wr_cmp_lo,
  input  logic              wr_cmp_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg_o,
  output logic [DATA_W-1:0] cfg_hi_o,
  output logic [CNT_W-1:0]  cmp_o
);
  logic [DATA_W-1:0] cfg_q;
  logic [CNT_W-1:0]  cmp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CH_CFG_RST;
      cmp_q <= '1;
    end else begin
      if (wr_cfg)    cfg_q <= (cfg_q & ~CH_WMASK) | (wdata & CH_WMASK);
      if (wr_cmp_lo) cmp_q[DATA_W-1:0] <= wdata;
      if (wr_cmp_hi) cmp_q[CNT_W-1:DATA_W] <= wdata;
    end
  end

  assign cfg_o    = cfg_q;
  assign cfg_hi_o = LINE_CAP;
  assign cmp_o    = cmp_q;

  a_r3_masked_write: assert property (@(posedge clk) disable iff (rst)
    wr_cfg |=> ((cfg_q & CH_WMASK) == ($past(wdata) & CH_WMASK)) &&
               ((cfg_q & ~CH_WMASK) == ($past(cfg_q) & ~CH_WMASK)));
  a_r3_cfg_stable: assert property (@(posedge clk) disable iff (rst)
    !wr_cfg |=> $stable(cfg_q));
  a_r7_cmp_stable: assert property (@(posedge clk) disable iff (rst)
    (!wr_cmp_lo && !wr_cmp_hi) |=> $stable(cmp_q));
endmodule

// File: rtl/evt_irq_router.sv
module evt_irq_router
  import evt_timer_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic                    legacy,
  input  logic [NCH-1:0]          fire,
  input  logic [NCH-1:0]          ch_en,
  input  logic [NCH*ROUTE_W-1:0]  route,
  output logic [NLINES-1:0]       irq_o
);
  localparam logic [ROUTE_W-1:0] LEG_LINE0 = ROUTE_W'(0);
  localparam logic [ROUTE_W-1:0] LEG_LINE1 = ROUTE_W'(8);

  logic [ROUTE_W-1:0] line [NCH];
  logic [NLINES-1:0]  irq_d;
  logic [NLINES-1:0]  irq_q;

  for (genvar n = 0; n < NCH; n++) begin : g_line
    if (n == 0) begin : g_leg0
      assign line[n] = legacy ? LEG_LINE0 : route[n*ROUTE_W +: ROUTE_W];
    end else if (n == 1) begin : g_leg1
      assign line[n] = legacy ? LEG_LINE1 : route[n*ROUTE_W +: ROUTE_W];
    end else begin : g_plain
      assign line[n] = route[n*ROUTE_W +: ROUTE_W];
    end
  end

  always_comb begin
    irq_d = '0;
    for (int n = 0; n < NCH; n++) begin
      if (run && fire[n] && ch_en[n]) irq_d[line[n]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  a_r8_quiet_when_halted: assert property (@(posedge clk) disable iff (rst)
    !run |=> irq_q == '0);
  a_r8_bounded_lines: assert property (@(posedge clk) disable iff (rst)
    $countones(irq_q) <= NCH);
  a_r9_legacy_line0: assert property (@(posedge clk) disable iff (rst)
    (legacy && run && fire[0] && ch_en[0]) |=> irq_q[0]);
  a_r9_legacy_line8: assert property (@(posedge clk) disable iff (rst)
    (legacy && run && fire[1] && ch_en[1]) |=> irq_q[8]);
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int             NCH       = 3,
  parameter logic [31:0]    PERIOD_FS = 32'h0098_9680,
  parameter logic [15:0]    VENDOR_ID = 16'h8086,
  parameter logic [31:0]    LINE_CAP  = 32'h0000_0C20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_en,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [NCH-1:0]        chan_fire,
  output logic [CNT_W-1:0]      cnt_o,
  output logic                  run_o,
  output logic [NCH*DATA_W-1:0] chan_cfg_o,
  output logic [NCH*CNT_W-1:0]  chan_cmp_o,
  output logic [NCH-1:0]        arm_o,
  output logic [NLINES-1:0]     irq_o
);
  localparam int          IDX_W  = ADDR_W - 5;
  localparam logic [31:0] CAP_LO = {VENDOR_ID, 1'b1, 1'b0, 1'b1, 5'(NCH - 1), 8'h01};

  // address decode
  logic [ADDR_W-1:0] rel;
  logic              in_ch;
  logic [IDX_W-1:0]  ch_idx;
  logic [2:0]        ch_word;
  logic              ch_word_ok;
  logic [7:0]        gword;

  assign rel        = bus_addr - CH_BASE;
  assign in_ch      = bus_addr[ADDR_W-1:8] != '0;
  assign ch_idx     = rel[ADDR_W-1:5];
  assign ch_word    = rel[4:2];
  assign ch_word_ok = rel[4] == 1'b0;
  assign gword      = bus_addr[ADDR_W-1:2];

  logic wr_gcfg, wr_cnt_lo, wr_cnt_hi;
  assign wr_gcfg   = bus_wr && !in_ch && gword == WA_GCFG;
  assign wr_cnt_lo = bus_wr && !in_ch && gword == WA_CNT_LO;
  assign wr_cnt_hi = bus_wr && !in_ch && gword == WA_CNT_HI;

  // global configuration
  logic run_q, leg_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      leg_q <= 1'b0;
    end else if (wr_gcfg) begin
      run_q <= bus_wdata[0];
      leg_q <= bus_wdata[1];
    end
  end
  assign run_o = run_q;

  evt_main_counter #(.CNT_W(CNT_W), .HALF_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .run     (run_q),
    .tick_en (tick_en),
    .wr_lo   (wr_cnt_lo),
    .wr_hi   (wr_cnt_hi),
    .wdata   (bus_wdata),
    .cnt_o   (cnt_o)
  );

  // channel register sets
  logic [DATA_W-1:0]      cfg_w    [NCH];
  logic [DATA_W-1:0]      cfg_hi_w [NCH];
  logic [CNT_W-1:0]       cmp_w    [NCH];
  logic [NCH-1:0]         ch_en;
  logic [NCH*ROUTE_W-1:0] route;
  logic [NCH-1:0]         cmp_wr;
  logic [NCH-1:0]         arm_d;
  logic [NCH-1:0]         arm_q;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic hit;
    assign hit = bus_wr && in_ch && ch_idx == IDX_W'(n);

    evt_chan_regs #(.LINE_CAP(LINE_CAP)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_cfg    (hit && ch_word == CW_CFG_LO),
      .wr_cmp_lo (hit && ch_word == CW_CMP_LO),
      .wr_cmp_hi (hit && ch_word == CW_CMP_HI),
      .wdata     (bus_wdata),
      .cfg_o     (cfg_w[n]),
      .cfg_hi_o  (cfg_hi_w[n]),
      .cmp_o     (cmp_w[n])
    );

    assign cmp_wr[n] = hit && (ch_word == CW_CMP_LO || ch_word == CW_CMP_HI);
    assign ch_en[n]  = cfg_w[n][CH_EN_BIT];
    assign route[n*ROUTE_W +: ROUTE_W] = cfg_w[n][ROUTE_LO +: ROUTE_W];
    assign chan_cfg_o[n*DATA_W +: DATA_W] = cfg_w[n];
    assign chan_cmp_o[n*CNT_W +: CNT_W]   = cmp_w[n];
    assign arm_d[n] = (wr_gcfg && bus_wdata[0] && !run_q && cmp_w[n] != '1) ||
                      (cmp_wr[n] && run_q);
  end

  always_ff @(posedge clk) begin
    if (rst) arm_q <= '0;
    else     arm_q <= arm_d;
  end
  assign arm_o = arm_q;

  evt_irq_router #(.NCH(NCH)) u_route (
    .clk    (clk),
    .rst    (rst),
    .run    (run_q),
    .legacy (leg_q),
    .fire   (chan_fire),
    .ch_en  (ch_en),
    .route  (route),
    .irq_o  (irq_o)
  );

  // read path
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    rd_mux = '0;
    if (in_ch) begin
      for (int n = 0; n < NCH; n++) begin
        if (ch_idx == IDX_W'(n) && ch_word_ok) begin
          case (ch_word)
            CW_CFG_LO: rd_mux = cfg_w[n];
            CW_CFG_HI: rd_mux = cfg_hi_w[n];
            CW_CMP_LO: rd_mux = cmp_w[n][DATA_W-1:0];
            CW_CMP_HI: rd_mux = cmp_w[n][CNT_W-1:DATA_W];
            default:   rd_mux = '0;
          endcase
        end
      end
    end else begin
      case (gword)
        WA_CAP_LO: rd_mux = CAP_LO;
        WA_CAP_HI: rd_mux = PERIOD_FS;
        WA_GCFG:   rd_mux = {30'd0, leg_q, run_q};
        WA_STAT:   rd_mux = '0;
        WA_CNT_LO: rd_mux = cnt_o[DATA_W-1:0];
        WA_CNT_HI: rd_mux = cnt_o[CNT_W-1:DATA_W];
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end
  assign bus_rdata = rdata_q;

  a_r7_arm_only_running: assert property (@(posedge clk) disable iff (rst)
    (arm_q != '0) |-> run_q);
  a_r10_far_channel_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && in_ch && ch_idx >= IDX_W'(NCH)) |=> bus_rdata == '0);
  a_r2_gcfg_readback: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !in_ch && gword == WA_GCFG) |=> bus_rdata[DATA_W-1:2] == '0);
endmodule

// File: tb/evt_timer_regs_tb.sv
module evt_timer_regs_tb_top;
  localparam int NCH = 3;
  localparam logic [31:0] PERIOD = 32'h0098_9680;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] chan_fire = '0;
  logic [63:0] cnt_o;
  logic        run_o;
  logic [NCH*32-1:0] chan_cfg_o;
  logic [NCH*64-1:0] chan_cmp_o;
  logic [NCH-1:0] arm_o;
  logic [31:0] irq_o;

  always #2.5 clk = ~clk;

  evt_timer_regs #(.NCH(NCH), .PERIOD_FS(PERIOD)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .chan_fire(chan_fire), .cnt_o(cnt_o),
    .run_o(run_o), .chan_cfg_o(chan_cfg_o), .chan_cmp_o(chan_cmp_o),
    .arm_o(arm_o), .irq_o(irq_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference model
  longint unsigned m_cnt;
  bit              m_run, m_leg;
  logic [31:0]     m_cfg [NCH];
  logic [63:0]     m_cmp [NCH];
  logic [31:0]     e_irq;
  logic [NCH-1:0]  e_arm;
  bit              model_live = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_run = 0; m_leg = 0; e_irq = '0; e_arm = '0;
      for (int c = 0; c < NCH; c++) begin
        m_cfg[c] = 32'h30; m_cmp[c] = '1;
      end
    end else begin
      bit run_before;
      bit cnt_written;
      run_before = m_run;
      cnt_written = 0;
      e_irq = '0;
      e_arm = '0;
      for (int c = 0; c < NCH; c++) begin
        if (chan_fire[c] && m_run && m_cfg[c][2]) begin
          int ln;
          ln = m_cfg[c][13:9];
          if (m_leg && c == 0) ln = 0;
          if (m_leg && c == 1) ln = 8;
          e_irq[ln] = 1'b1;
        end
      end
      if (bus_wr) begin
        int a;
        a = bus_addr;
        if (a >= 'h100) begin
          int c, o;
          c = (a - 'h100) / 32;
          o = (a - 'h100) % 32;
          if (c < NCH) begin
            if (o == 0) m_cfg[c] = (m_cfg[c] & ~32'h3E4E) | (bus_wdata & 32'h3E4E);
            if (o == 8)  begin m_cmp[c][31:0]  = bus_wdata; if (run_before) e_arm[c] = 1; end
            if (o == 12) begin m_cmp[c][63:32] = bus_wdata; if (run_before) e_arm[c] = 1; end
          end
        end else if (a == 'h10) begin
          if (!run_before && bus_wdata[0])
            for (int c = 0; c < NCH; c++) if (m_cmp[c] != '1) e_arm[c] = 1;
          m_run = bus_wdata[0];
          m_leg = bus_wdata[1];
        end else if (a == 'hF0) begin
          m_cnt[31:0] = bus_wdata; cnt_written = 1;
        end else if (a == 'hF4) begin
          m_cnt[63:32] = bus_wdata; cnt_written = 1;
        end
      end
      if (!cnt_written && run_before && tick_en) m_cnt = m_cnt + 1;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (model_live) begin
      checks++;
      if (cnt_o !== m_cnt) begin
        errors++;
        $display("FAIL R5 counter actual=%h expected=%h", cnt_o, m_cnt);
      end
      checks++;
      if (irq_o !== e_irq) begin
        errors++;
        $display("FAIL R8 irq actual=%h expected=%h", irq_o, e_irq);
      end
      checks++;
      if (arm_o !== e_arm) begin
        errors++;
        $display("FAIL R7 arm actual=%b expected=%b", arm_o, e_arm);
      end
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [9:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s read @%h actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic fire_chk(input logic [NCH-1:0] f, input logic [31:0] exp, input string tag);
    @(negedge clk);
    chan_fire = f;
    @(negedge clk);
    chan_fire = '0;
    checks++;
    if (irq_o !== exp) begin
      errors++;
      $display("FAIL %s irq actual=%h expected=%h", tag, irq_o, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R5 actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_live = 1'b1;

    // R1 reset values
    rd_chk(10'h000, 32'h8086A201, "R1 cap lo");
    rd_chk(10'h004, PERIOD, "R1 cap hi");
    rd_chk(10'h120, 32'h30, "R1 ch1 cfg");
    rd_chk(10'h144, 32'hC20, "R1 ch2 cfg hi");
    rd_chk(10'h108, 32'hFFFFFFFF, "R1 ch0 cmp lo");
    rd_chk(10'h0F4, 32'h0, "R1 counter hi");

    // R2 global config mask
    wr(10'h010, 32'hFFFF_FFFC);
    rd_chk(10'h010, 32'h0, "R2 reserved bits");
    wr(10'h010, 32'h2);
    rd_chk(10'h010, 32'h2, "R2 legacy bit");
    wr(10'h010, 32'h0);

    // R3 channel config mask and read-only high word
    wr(10'h120, 32'hFFFF_FFFF);
    rd_chk(10'h120, 32'h3E7E, "R3 masked write");
    wr(10'h124, 32'h0);
    rd_chk(10'h124, 32'hC20, "R3 read-only high");
    wr(10'h120, 32'h0);
    rd_chk(10'h120, 32'h30, "R3 clear writable");

    // R4 ignored writes
    wr(10'h000, 32'h0);
    wr(10'h004, 32'h1);
    wr(10'h020, 32'hFFFF_FFFF);
    rd_chk(10'h000, 32'h8086A201, "R4 cap lo");
    rd_chk(10'h004, PERIOD, "R4 cap hi");
    rd_chk(10'h020, 32'h0, "R4 status");

    // R6 counter halves, halted so ticks have no effect (R5)
    wr(10'h0F0, 32'hFFFF_FFFD);
    wr(10'h0F4, 32'h0000_0001);
    ticks(3);
    rd_chk(10'h0F0, 32'hFFFF_FFFD, "R5 halted hold lo");
    rd_chk(10'h0F4, 32'h1, "R6 high half");

    // R7 re-arm on run rise: only ch0 has a real comparator
    wr(10'h108, 32'd500);
    wr(10'h10C, 32'd0);
    @(negedge clk);
    bus_addr = 10'h010; bus_wdata = 32'h1; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    checks++;
    if (arm_o !== 3'b001) begin
      errors++;
      $display("FAIL R7 arm on run actual=%b expected=%b", arm_o, 3'b001);
    end

    // R5 counting across the 32-bit boundary
    ticks(5);
    rd_chk(10'h0F4, 32'h2, "R5 carry into high");
    rd_chk(10'h0F0, 32'h2, "R5 low after carry");
    // R6 write beats tick in same cycle
    @(negedge clk);
    bus_addr = 10'h0F0; bus_wdata = 32'h10; bus_wr = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_en = 1'b0;
    rd_chk(10'h0F0, 32'h10, "R6 write priority");

    // R7 comparator write while running
    wr(10'h148, 32'd77);

    // R8 routing
    wr(10'h140, 32'h0000_0A04);
    fire_chk(3'b100, 32'h0000_0020, "R8 ch2 line5");
    wr(10'h100, 32'h0000_0600);
    fire_chk(3'b001, 32'h0, "R8 ch0 disabled");
    wr(10'h100, 32'h0000_0E04);
    wr(10'h120, 32'h0000_0E04);
    fire_chk(3'b011, 32'h0000_0080, "R8 shared line7");

    // R9 legacy routing
    wr(10'h010, 32'h3);
    fire_chk(3'b111, 32'h0000_0121, "R9 legacy lines");
    wr(10'h010, 32'h1);
    fire_chk(3'b011, 32'h0000_0080, "R9 legacy off");

    // R8 halted suppresses interrupts; R5 counter frozen
    wr(10'h010, 32'h0);
    fire_chk(3'b111, 32'h0, "R8 halted");
    ticks(4);
    rd_chk(10'h0F0, 32'h10, "R5 frozen after halt");

    // R10 unmapped reads
    rd_chk(10'h160, 32'h0, "R10 channel 3");
    rd_chk(10'h3E0, 32'h0, "R10 last window");
    rd_chk(10'h110, 32'h0, "R10 ch0 undefined offset");
    rd_chk(10'h0F8, 32'h0, "R10 global undefined");
    rd_chk(10'h014, 32'h0, "R10 gcfg high");

    repeat (2) @(negedge clk);
    done = 1'b1;
    model_live = 1'b0;
    summary();
    $finish;
  end
endmodule